// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel 24-bit sample words. The stream arrives as a bit clock, a frame (left/right) clock and one data line. Samples are sent MSB first in two's complement, and the left word of a frame always comes before the right word. Four framing formats can be selected: right-justified, I2S, left-justified, and a DSP format in which a short frame-clock pulse marks the start of each channel word. The receiver supports a nominal 64-bit-clock frame and also a packed 32-bit-clock frame.

All three serial lines are brought into the block's own clock domain through a synchronizer chain. The bit clock is then edge-detected, so the block clock must run at least four times faster than the bit clock. A word is committed when the next word starts. Once a right word that follows a left word has been committed, the pair is presented on the outputs together with a one-cycle valid strobe. Each channel also has a zero flag. It rises after a long unbroken run of all-zero words on that channel and falls at the first nonzero word.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset, both output words are zero and valid and both zero flags are low.
- R2: With format select 2'b10 (left-justified), the frame clock is high for the left word. Data is sampled on rising bit-clock edges, and the MSB is the bit sampled at the first rising edge after a frame-clock change.
- R3: With format select 2'b01 (I2S), the frame clock is low for the left word. Data is sampled on rising edges, and the MSB arrives one bit clock after the frame-clock change.
- R4: With format select 2'b00 (right-justified), the frame clock is high for left and data is sampled on rising edges. The word is the last N bits before the frame-clock change, where the word-length select is 2'b00 = 24, 2'b01 = 20, 2'b10 = 16, 2'b11 = 24. In a 32-bit-clock half frame this puts the MSB at bit-clock position 8, 12 or 16 (counting from 0).
- R5: With format select 2'b11 (DSP), data is sampled on falling bit-clock edges. A word's MSB is the first bit sampled with the frame clock low after a sample with it high. The first such word after reset is left, and words then alternate between left and right.
- R6: Outside right-justified mode, bits beyond the 24th are dropped. A shorter word is left-aligned in the 24-bit output, and its unused low bits are zero.
- R7: valid is high for exactly one cycle per left/right pair, after the right word is committed. The outputs change only in that cycle.
- R8: Packed frames of 16 bit clocks per channel decode correctly in left-justified mode and in right-justified mode with a 16-bit word length.
- R9: A channel's zero flag rises when that channel commits its 1025th consecutive all-zero word, and not earlier.
- R10: A channel's zero flag falls when that channel commits a nonzero word. The two channels' flags are independent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Frame (channel select) clock |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing format select (see R2-R5 encodings) |
| wlen_i | input | 2 | Right-justified word length select |
| left_o | output | 24 | Left sample, left-aligned two's complement |
| right_o | output | 24 | Right sample, left-aligned two's complement |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |
| zero_l_o | output | 1 | Left channel long-zero flag |
| zero_r_o | output | 1 | Right channel long-zero flag |

## Verification
The hardest condition to reach is the zero-flag threshold. It needs more than a thousand consecutive zero words on one channel while the other channel keeps carrying data, and the flag must be seen to stay low after exactly 1024 words. The stimulus reaches it quickly by sending packed 16-bit-clock left-justified frames whose left word is zero and whose right word is forced nonzero. It samples both flags after the 1024th frame, after the 1025th frame, and after one nonzero left word. The other tests feed each format with random words plus the most-negative and most-positive directed values, including truncated 32-bit and short zero-padded words.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        FMT_RJ  = 2'b00,
        FMT_I2S = 2'b01,
        FMT_LJ  = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        WL_24  = 2'b00,
        WL_20  = 2'b01,
        WL_16  = 2'b10,
        WL_24B = 2'b11
    } wlen_e;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic lrclk_i,
    input  logic sdata_i,
    output logic lr_o,
    output logic dat_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] bck;
        logic [STAGES-1:0] lr;
        logic [STAGES-1:0] dat;
        logic              bck_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.bck      = STAGES'({q.bck, bclk_i});
        d.lr       = STAGES'({q.lr, lrclk_i});
        d.dat      = STAGES'({q.dat, sdata_i});
        d.bck_prev = q.bck[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Line and data are taken from the same stage as the bit clock,
    // so all three stay aligned at the detected edge.
    assign lr_o   = q.lr[STAGES-1];
    assign dat_o  = q.dat[STAGES-1];
    assign rise_o = q.bck[STAGES-1] & ~q.bck_prev;
    assign fall_o = ~q.bck[STAGES-1] & q.bck_prev;

endmodule

// File: rtl/sar_frame_core.sv
module sar_frame_core
    import sar_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt_i,
    input  logic [1:0]        wlen_i,
    input  logic              lr_i,
    input  logic              dat_i,
    input  logic              rise_i,
    input  logic              fall_i,
    output logic              commit_l_o,
    output logic              commit_r_o,
    output logic [DATA_W-1:0] word_o
);

    localparam int POS_W = $clog2(DATA_W + 1);
    localparam int SH20  = DATA_W - 20;
    localparam int SH16  = DATA_W - 16;

    typedef struct packed {
        logic              prev_lr;
        chan_e             chan;
        logic              active;
        logic              pend;
        logic [POS_W-1:0]  pos;
        logic [DATA_W-1:0] shift;
        logic [DATA_W-1:0] slide;
        logic              commit_l;
        logic              commit_r;
        logic [DATA_W-1:0] word;
    } core_t;

    core_t q, d;

    logic              samp;
    logic              trans;
    logic              start;
    logic              commit;
    chan_e             new_chan;
    logic [DATA_W-1:0] cm_word;
    logic [DATA_W-1:0] rj_word;

    // Right-justified word: the newest N bits, moved up to the MSB end.
    always_comb begin
        unique case (wlen_e'(wlen_i))
            WL_20:   rj_word = q.slide << SH20;
            WL_16:   rj_word = q.slide << SH16;
            default: rj_word = q.slide;
        endcase
    end

    always_comb begin
        d          = q;
        d.commit_l = 1'b0;
        d.commit_r = 1'b0;
        samp       = (fmt_e'(fmt_i) == FMT_DSP) ? fall_i : rise_i;
        trans      = lr_i ^ q.prev_lr;
        start      = 1'b0;
        commit     = 1'b0;
        new_chan   = CH_LEFT;
        cm_word    = q.shift;

        if (samp) begin
            d.prev_lr = lr_i;
            d.slide   = {q.slide[DATA_W-2:0], dat_i};
            if (q.pos < POS_W'(DATA_W)) begin
                d.shift[POS_W'(DATA_W-1) - q.pos] = dat_i;
                d.pos = q.pos + POS_W'(1);
            end

            unique case (fmt_e'(fmt_i))
                FMT_LJ: begin
                    start    = trans;
                    new_chan = lr_i ? CH_LEFT : CH_RIGHT;
                end
                FMT_I2S: begin
                    d.pend   = trans;
                    start    = q.pend;
                    new_chan = lr_i ? CH_RIGHT : CH_LEFT;
                end
                FMT_DSP: begin
                    start    = q.prev_lr & ~lr_i;
                    new_chan = (q.active && q.chan == CH_LEFT) ? CH_RIGHT : CH_LEFT;
                end
                default: begin
                    if (trans) begin
                        commit   = q.active;
                        cm_word  = rj_word;
                        d.active = 1'b1;
                        d.chan   = lr_i ? CH_LEFT : CH_RIGHT;
                    end
                end
            endcase

            if (start) begin
                commit                = q.active;
                d.active              = 1'b1;
                d.chan                = new_chan;
                d.shift               = '0;
                d.shift[DATA_W-1]     = dat_i;
                d.pos                 = POS_W'(1);
            end

            if (commit) begin
                d.word     = cm_word;
                d.commit_l = (q.chan == CH_LEFT);
                d.commit_r = (q.chan == CH_RIGHT);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign commit_l_o = q.commit_l;
    assign commit_r_o = q.commit_r;
    assign word_o     = q.word;

endmodule

// File: rtl/sar_zero_watch.sv
module sar_zero_watch #(
    parameter int DATA_W      = 24,
    parameter int ZERO_FRAMES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              flag_o
);

    localparam int CNT_MAX = ZERO_FRAMES + 1;
    localparam int CNT_W   = $clog2(ZERO_FRAMES + 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } zw_t;

    zw_t q, d;

    always_comb begin
        d = q;
        if (commit_i) begin
            if (word_i == '0) begin
                if (q.cnt != CNT_W'(CNT_MAX)) d.cnt = q.cnt + CNT_W'(1);
                d.flag = (q.cnt >= CNT_W'(ZERO_FRAMES));
            end else begin
                d.cnt  = '0;
                d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag_o = q.flag;

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
    parameter int DATA_W      = 24,
    parameter int SYNC_STAGES = 2,
    parameter int ZERO_FRAMES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_i,
    input  logic              lrclk_i,
    input  logic              sdata_i,
    input  logic [1:0]        fmt_i,
    input  logic [1:0]        wlen_i,
    output logic [DATA_W-1:0] left_o,
    output logic [DATA_W-1:0] right_o,
    output logic              valid_o,
    output logic              zero_l_o,
    output logic              zero_r_o
);

    localparam int NCH = 2;

    logic              s_lr, s_dat, s_rise, s_fall;
    logic              cm_l, cm_r;
    logic [DATA_W-1:0] cm_word;
    logic [NCH-1:0]    cm_vec;
    logic [NCH-1:0]    zflag;

    sar_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_i  (bclk_i),
        .lrclk_i (lrclk_i),
        .sdata_i (sdata_i),
        .lr_o    (s_lr),
        .dat_o   (s_dat),
        .rise_o  (s_rise),
        .fall_o  (s_fall)
    );

    sar_frame_core #(.DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_i      (fmt_i),
        .wlen_i     (wlen_i),
        .lr_i       (s_lr),
        .dat_i      (s_dat),
        .rise_i     (s_rise),
        .fall_i     (s_fall),
        .commit_l_o (cm_l),
        .commit_r_o (cm_r),
        .word_o     (cm_word)
    );

    assign cm_vec = {cm_r, cm_l};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_zero
        sar_zero_watch #(
            .DATA_W      (DATA_W),
            .ZERO_FRAMES (ZERO_FRAMES)
        ) u_zw (
            .clk      (clk),
            .rst_n    (rst_n),
            .commit_i (cm_vec[ch]),
            .word_i   (cm_word),
            .flag_o   (zflag[ch])
        );
    end

    assign zero_l_o = zflag[0];
    assign zero_r_o = zflag[1];

    // Pairing stage: hold the left word until its right partner lands.
    typedef struct packed {
        logic [DATA_W-1:0] lhold;
        logic              lseen;
        logic [DATA_W-1:0] left;
        logic [DATA_W-1:0] right;
        logic              valid;
    } pair_t;

    pair_t q, d;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (cm_l) begin
            d.lhold = cm_word;
            d.lseen = 1'b1;
        end else if (cm_r && q.lseen) begin
            d.left  = q.lhold;
            d.right = cm_word;
            d.valid = 1'b1;
            d.lseen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign left_o  = q.left;
    assign right_o = q.right;
    assign valid_o = q.valid;

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid,
    input logic [DATA_W-1:0] left,
    input logic [DATA_W-1:0] right,
    input logic              zero_l,
    input logic              zero_r,
    input logic              commit_l,
    input logic              commit_r,
    input logic [DATA_W-1:0] word
);

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ($stable(left) && $stable(right)));

    // R7
    valid_after_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(commit_r));

    // R9
    zl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_l) |-> $past(commit_l && word == '0));

    // R9
    zr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_r) |-> $past(commit_r && word == '0));

    // R10
    zl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(zero_l) |-> $past(commit_l && word != '0));

    // R10
    zr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(zero_r) |-> $past(commit_r && word != '0));

endmodule

bind serial_audio_rx serial_audio_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (valid_o),
    .left     (left_o),
    .right    (right_o),
    .zero_l   (zero_l_o),
    .zero_r   (zero_r_o),
    .commit_l (cm_l),
    .commit_r (cm_r),
    .word     (cm_word)
);

// File: tb/tb_serial_audio_rx.sv
module tb_serial_audio_rx;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        lrclk = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic [1:0]  wlen = 2'b00;
    logic [23:0] left_o, right_o;
    logic        valid_o, zero_l_o, zero_r_o;

    int checks = 0;
    int errors = 0;
    bit dsp_mode = 1'b0;
    bit timed_out = 1'b0;

    int          ng_total = 0;
    int          grp_base = 0;
    logic [23:0] got_l [64];
    logic [23:0] got_r [64];
    logic [23:0] exp_l [64];
    logic [23:0] exp_r [64];

    serial_audio_rx dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_i   (bclk),
        .lrclk_i  (lrclk),
        .sdata_i  (sdata),
        .fmt_i    (fmt),
        .wlen_i   (wlen),
        .left_o   (left_o),
        .right_o  (right_o),
        .valid_o  (valid_o),
        .zero_l_o (zero_l_o),
        .zero_r_o (zero_r_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (ng_total - grp_base >= 0 && ng_total - grp_base < 64) begin
                got_l[ng_total - grp_base] = left_o;
                got_r[ng_total - grp_base] = right_o;
            end
            ng_total = ng_total + 1;
        end
    end

    function automatic logic [31:0] mask(input int n);
        if (n >= 32) return 32'hFFFF_FFFF;
        return (32'h1 << n) - 32'h1;
    endfunction

    function automatic logic [23:0] exp_word(input logic [31:0] v, input int w,
                                             input logic [1:0] f, input logic [1:0] wl);
        int n;
        if (f == 2'b00) begin
            n = (wl == 2'b01) ? 20 : (wl == 2'b10) ? 16 : 24;
            return 24'((v & mask(n)) << (24 - n));
        end
        if (w >= 24) return 24'(v >> (w - 24));
        return 24'(v << (24 - w));
    endfunction

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] expv, input string what);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic drive_bit(input logic lr, input logic b);
        @(negedge clk);
        bclk  = dsp_mode;
        lrclk = lr;
        sdata = b;
        @(negedge clk);
        @(negedge clk);
        bclk = ~dsp_mode;
        @(negedge clk);
    endtask

    task automatic send_half(input logic lr_lvl, input logic [31:0] v, input int w,
                             input int slots, input int lead, input bit pulse);
        for (int i = 0; i < slots; i++) begin
            int   k = i - lead;
            logic b = (k >= 0 && k < w) ? v[w-1-k] : 1'b0;
            drive_bit(pulse ? (i == 0) : lr_lvl, b);
        end
    endtask

    task automatic do_reset(input logic [1:0] f, input logic [1:0] wl);
        @(negedge clk);
        rst_n    = 1'b0;
        fmt      = f;
        wlen     = wl;
        dsp_mode = (f == 2'b11);
        bclk     = 1'b0;
        lrclk    = (f == 2'b01);
        sdata    = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_group(input logic [1:0] f, input logic [1:0] wl, input int w,
                             input int slots, input int nfr, input string req);
        int   lead;
        logic lr_left;
        bit   pulse;
        do_reset(f, wl);
        grp_base = ng_total;
        lead    = (f == 2'b10) ? 0 : (f == 2'b00) ? (slots - w) : 1;
        lr_left = (f == 2'b01) ? 1'b0 : 1'b1;
        pulse   = (f == 2'b11);
        for (int p = 0; p < 3; p++) drive_bit((f == 2'b01), 1'b0);
        for (int fr = 0; fr < nfr; fr++) begin
            logic [31:0] lv, rv;
            if (fr == 0) begin
                lv = 32'h1 << (w - 1);
                rv = mask(w) >> 1;
            end else if (fr == 1) begin
                lv = mask(w);
                rv = 32'h0;
            end else begin
                lv = $urandom & mask(w);
                rv = $urandom & mask(w);
            end
            exp_l[fr] = exp_word(lv, w, f, wl);
            exp_r[fr] = exp_word(rv, w, f, wl);
            send_half(lr_left, lv, w, slots, lead, pulse);
            send_half(~lr_left, rv, w, slots, lead, pulse);
        end
        send_half(lr_left, 32'h0, w, slots, lead, pulse);
        repeat (12) @(negedge clk);
        chk("R7", ng_total - grp_base, nfr, "pair count");
        for (int i = 0; i < nfr; i++) begin
            chk(req, {8'h0, got_l[i]}, {8'h0, exp_l[i]}, $sformatf("left word %0d", i));
            chk(req, {8'h0, got_r[i]}, {8'h0, exp_r[i]}, $sformatf("right word %0d", i));
        end
    endtask

    task automatic zero_test();
        do_reset(2'b10, 2'b00);
        for (int p = 0; p < 3; p++) drive_bit(1'b0, 1'b0);
        for (int fr = 0; fr < 1024; fr++) begin
            send_half(1'b1, 32'h0, 16, 16, 0, 1'b0);
            send_half(1'b0, ($urandom & 32'hFFFF) | 32'h1, 16, 16, 0, 1'b0);
        end
        repeat (4) @(negedge clk);
        chk("R9", zero_l_o, 1'b0, "left flag after 1024 zero words");
        send_half(1'b1, 32'h0, 16, 16, 0, 1'b0);
        send_half(1'b0, 32'h0055, 16, 16, 0, 1'b0);
        repeat (4) @(negedge clk);
        chk("R9", zero_l_o, 1'b1, "left flag after 1025 zero words");
        chk("R10", zero_r_o, 1'b0, "right flag with nonzero right data");
        send_half(1'b1, 32'h0100, 16, 16, 0, 1'b0);
        send_half(1'b0, 32'h0033, 16, 16, 0, 1'b0);
        repeat (4) @(negedge clk);
        chk("R10", zero_l_o, 1'b0, "left flag after nonzero word");
    endtask

    task automatic all_tests();
        void'($urandom(32'd20240611));
        do_reset(2'b00, 2'b00);
        chk("R1", {8'h0, left_o}, 32'h0, "left after reset");
        chk("R1", {8'h0, right_o}, 32'h0, "right after reset");
        chk("R1", valid_o, 1'b0, "valid after reset");
        chk("R1", {zero_r_o, zero_l_o}, 2'b00, "zero flags after reset");

        run_group(2'b10, 2'b00, 24, 32, 5, "R2");
        run_group(2'b01, 2'b00, 24, 32, 5, "R3");
        run_group(2'b00, 2'b00, 24, 32, 4, "R4");
        run_group(2'b00, 2'b01, 20, 32, 4, "R4");
        run_group(2'b00, 2'b10, 16, 32, 4, "R4");
        run_group(2'b00, 2'b11, 24, 32, 3, "R4");
        run_group(2'b11, 2'b00, 24, 32, 5, "R5");
        run_group(2'b11, 2'b00, 18, 32, 4, "R6");
        run_group(2'b10, 2'b00, 32, 32, 4, "R6");
        run_group(2'b01, 2'b00, 20, 32, 4, "R6");
        run_group(2'b10, 2'b00, 16, 16, 5, "R8");
        run_group(2'b00, 2'b10, 16, 16, 5, "R8");
        zero_test();
    endtask

    initial begin
        fork
            begin
                all_tests();
            end
            begin
                repeat (WATCHDOG) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog: actual=timeout expected=completion within %0d cycles",
                     WATCHDOG);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule